// File: doc/BRIEF.md
# Streaming Flash Buffer-Program Sequencer

This block is the command front end of a flash device's streaming factory-programming mode. The host starts the mode with two bus write cycles: a setup code at the first-word address, then a confirm code. The block checks three things at that point: the programming voltage, the lock bit of the target erase block, and the 32-word alignment of the start address. If all of them pass, the block enters its load phase. From then on, every write to that same first-word address carries one data word into a 32-word buffer. A full buffer is committed word by word into a behavioural array model and checked as it goes. After each commit the internal array pointer moves on to the next 32-word boundary by itself, so the host only repeats "fill, wait for not-busy".

A write to any other address ends the stream. Any words already in a partly filled buffer are committed first. Faults set sticky bits in an 8-bit status word that the host polls. These faults are a rejected confirm, low voltage, a failed check during a commit, and an attempt to write past the end of the erase block. The status bits stay set until the host issues a clear-status code while the block is idle.

Host writes use a valid/ready handshake. A write is taken on a rising clock edge when `wr_valid` and `wr_ready` are both high. While `wr_valid` is high and `wr_ready` is low, the host must hold `wr_addr` and `wr_data` steady. `wr_ready` drops only while a buffer commit is running and rises again when the commit ends. The status, voltage, lock and array-read pins are plain level signals.

Top module: `stream_prog_seq`

## Requirements
- R1: After reset the status word reads 0x80 (bit 7 = idle, no error bits), `wr_ready` is high and every array word reads all ones.
- R2: In idle, a write whose low data byte is 0x80 records the write address. A following write with low byte 0xD0 is accepted when `vpp_ok` is high, the lock bit of the recorded address's erase block is low, and the address bits [4:0] are zero. The block then enters the load phase and the status reads 0x00.
- R3: A second write whose low byte is not 0xD0, or an accepted code with a locked block or a misaligned address, sets status bit 4 and returns to idle. The status then reads 0x90.
- R4: A 0xD0 confirm while `vpp_ok` is low sets status bits 4 and 3 and returns to idle, so the status reads 0x98.
- R5: In the load phase, 32 writes to the first-word address fill the buffer. The commit then holds status bit 0 high for exactly 32 cycles and puts word i at array address pointer+i. After the commit, bit 0 returns low with the block still in the load phase.
- R6: Each buffer after the first lands 32 words above the previous one, with no address supplied by the host.
- R7: In the load phase, a write to any address other than the first-word address ends the mode. Words already in a partly filled buffer are committed, and the unfilled positions leave their array words unchanged. The status then reads 0x80.
- R8: A data write after the last buffer of an erase block has been committed sets status bits 5 and 4 and returns to idle. The array is not written, so the status reads 0xB0.
- R9: During a commit, each word is read back after programming. Programming can only clear bits. If the readback differs from the buffer word, the block sets status bit 4, stops the commit and returns to idle.
- R10: Error bits 5, 4 and 3 hold until a write with low byte 0x50 is accepted while the block is idle. Any other code written in idle leaves the status unchanged.
- R11: `wr_ready` is low whenever status bit 0 (commit busy) is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host write cycle present |
| wr_ready | output | 1 | Block can accept a write this cycle |
| wr_addr | input | ADDR_W | Host word address |
| wr_data | input | DATA_W | Host data; low byte is decoded as a command outside the load phase |
| vpp_ok | input | 1 | Programming voltage above its lockout level |
| blk_lock | input | NBLK | One lock bit per erase block, high = locked |
| status_o | output | 8 | Status: 7 idle, 5 sequence error, 4 program error, 3 voltage error, 0 commit busy |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array word at `rd_addr` |

## Verification
The entry checks are exercised in several ways. Confirms that pass use two different aligned starts in the two erase blocks. Confirms that fail use a wrong code, a misaligned start, a locked block and low voltage, and each failure must leave its own status value. Streaming is tried with two full buffers that run to the end of an erase block. Those words must land in consecutive 32-word windows, which would catch a pointer that does not advance, and a further write must be refused. The other cases are a five-word partial buffer closed by an exit write, which separates committed words from untouched ones, and a rewrite of already-programmed words, which shows the verify abort stopping after one word.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CONFIRM,
    ST_LOAD,
    ST_COMMIT
  } seq_state_e;

  localparam logic [7:0] CMD_SETUP   = 8'h80;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;

  localparam int SB_IDLE = 7;
  localparam int SB_SEQ  = 5;
  localparam int SB_PROG = 4;
  localparam int SB_VOLT = 3;
  localparam int SB_BUSY = 0;
endpackage

// File: rtl/sp_buffer.sv
// Word buffer between host writes and the array commit; empty words hold all ones.
module sp_buffer #(
  parameter int DATA_W = 16,
  parameter int BUF_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [BUF_W-1:0]  ld_idx,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              clr,
  input  logic [BUF_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  localparam int BUF_N = 1 << BUF_W;

  logic [DATA_W-1:0] word_q [BUF_N];

  for (genvar g = 0; g < BUF_N; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 word_q[g] <= '1;
      else if (clr)                               word_q[g] <= '1;
      else if (ld_en && ld_idx == BUF_W'(g))      word_q[g] <= ld_data;
    end
  end

  assign rd_data = word_q[rd_idx];
endmodule

// File: rtl/sp_array.sv
// Behavioural flash array: erased to ones, programming can only clear bits.
module sp_array #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_en,
  input  logic [ADDR_W-1:0] pg_addr,
  input  logic [DATA_W-1:0] pg_data,
  input  logic [ADDR_W-1:0] va_addr,
  output logic [DATA_W-1:0] va_data,
  input  logic [ADDR_W-1:0] ha_addr,
  output logic [DATA_W-1:0] ha_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cell_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 cell_q[g] <= '1;
      else if (pg_en && pg_addr == ADDR_W'(g))    cell_q[g] <= cell_q[g] & pg_data;
    end
  end

  assign va_data = cell_q[va_addr];
  assign ha_data = cell_q[ha_addr];
endmodule

// File: rtl/stream_prog_seq.sv
module stream_prog_seq #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 7,
  parameter int BLK_W  = 6,
  parameter int BUF_W  = 5,
  localparam int NBLK  = 1 << (ADDR_W - BLK_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              vpp_ok,
  input  logic [NBLK-1:0]   blk_lock,
  output logic [7:0]        status_o,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  import sp_pkg::*;

  localparam int BUF_N = 1 << BUF_W;
  localparam logic [BUF_W-1:0] LAST_IDX = BUF_W'(BUF_N - 1);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] wa0_q, ptr_q;
  logic [BUF_W-1:0]  fill_q, cidx_q;
  logic              exit_pend_q, blk_end_q;
  logic              err_seq_q, err_prog_q, err_volt_q;

  logic              fire, same_addr, entry_bad, verify_bad, last_word, buf_clr, ld_en;
  logic [7:0]        code;
  logic [ADDR_W-1:0] pg_addr, ptr_next;
  logic [DATA_W-1:0] buf_word, arr_word, readback;

  assign fire      = wr_valid && wr_ready;
  assign code      = wr_data[7:0];
  assign same_addr = (wr_addr == wa0_q);
  assign wr_ready  = (state_q != ST_COMMIT);

  // Entry conditions checked on the confirm cycle.
  assign entry_bad = (code != CMD_CONFIRM) || !vpp_ok
                  || blk_lock[wa0_q[ADDR_W-1:BLK_W]]
                  || (wa0_q[BUF_W-1:0] != '0);

  // Commit datapath: one buffer word per cycle, readback compared after the AND.
  assign pg_addr    = ptr_q + ADDR_W'(cidx_q);
  assign readback   = arr_word & buf_word;
  assign verify_bad = (state_q == ST_COMMIT) && (readback != buf_word);
  assign last_word  = (cidx_q == LAST_IDX);
  assign buf_clr    = (state_q == ST_COMMIT) && (verify_bad || last_word);
  assign ld_en      = (state_q == ST_LOAD) && fire && same_addr && !blk_end_q;
  assign ptr_next   = ptr_q + ADDR_W'(BUF_N);

  sp_buffer #(.DATA_W(DATA_W), .BUF_W(BUF_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (ld_en),
    .ld_idx  (fill_q),
    .ld_data (wr_data),
    .clr     (buf_clr),
    .rd_idx  (cidx_q),
    .rd_data (buf_word)
  );

  sp_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .pg_en   (state_q == ST_COMMIT),
    .pg_addr (pg_addr),
    .pg_data (buf_word),
    .va_addr (pg_addr),
    .va_data (arr_word),
    .ha_addr (rd_addr),
    .ha_data (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      wa0_q       <= '0;
      ptr_q       <= '0;
      fill_q      <= '0;
      cidx_q      <= '0;
      exit_pend_q <= 1'b0;
      blk_end_q   <= 1'b0;
      err_seq_q   <= 1'b0;
      err_prog_q  <= 1'b0;
      err_volt_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (fire && code == CMD_SETUP) begin
            wa0_q   <= wr_addr;
            state_q <= ST_CONFIRM;
          end else if (fire && code == CMD_CLEAR) begin
            err_seq_q  <= 1'b0;
            err_prog_q <= 1'b0;
            err_volt_q <= 1'b0;
          end
        end
        ST_CONFIRM: begin
          if (fire) begin
            if (entry_bad) begin
              err_prog_q <= 1'b1;
              if (code == CMD_CONFIRM && !vpp_ok) err_volt_q <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              ptr_q       <= wa0_q;
              fill_q      <= '0;
              exit_pend_q <= 1'b0;
              blk_end_q   <= 1'b0;
              state_q     <= ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          if (fire) begin
            if (!same_addr) begin
              if (fill_q == '0) begin
                state_q <= ST_IDLE;
              end else begin
                exit_pend_q <= 1'b1;
                cidx_q      <= '0;
                state_q     <= ST_COMMIT;
              end
            end else if (blk_end_q) begin
              err_seq_q  <= 1'b1;
              err_prog_q <= 1'b1;
              state_q    <= ST_IDLE;
            end else begin
              fill_q <= fill_q + 1'b1;
              if (fill_q == LAST_IDX) begin
                cidx_q  <= '0;
                state_q <= ST_COMMIT;
              end
            end
          end
        end
        ST_COMMIT: begin
          if (verify_bad) begin
            err_prog_q <= 1'b1;
            state_q    <= ST_IDLE;
          end else if (last_word) begin
            fill_q    <= '0;
            ptr_q     <= ptr_next;
            blk_end_q <= (ptr_next[BLK_W-1:0] == '0);
            state_q   <= exit_pend_q ? ST_IDLE : ST_LOAD;
          end else begin
            cidx_q <= cidx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    status_o          = '0;
    status_o[SB_IDLE] = (state_q == ST_IDLE);
    status_o[SB_SEQ]  = err_seq_q;
    status_o[SB_PROG] = err_prog_q;
    status_o[SB_VOLT] = err_volt_q;
    status_o[SB_BUSY] = (state_q == ST_COMMIT);
  end
endmodule

// File: rtl/sp_checks.sv
module sp_checks #(
  parameter int BUF_W = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [7:0] wr_code,
  input logic [7:0] status_o
);
  localparam int BUF_N = 1 << BUF_W;

  logic [BUF_W:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run_cnt <= '0;
    else if (status_o[0]) run_cnt <= run_cnt + 1'b1;
    else                  run_cnt <= '0;
  end

  assert_idle_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[7] |-> (wr_ready && !status_o[0]));

  assert_commit_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(status_o[0]) && !$rose(status_o[4])) |-> (run_cnt == (BUF_W+1)'(BUF_N)));

  assert_volt_with_prog_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[3]) |-> (status_o[4] && status_o[7]));

  assert_seq_with_prog_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_o[5]) |-> (status_o[4] && status_o[7]));

  assert_sticky_prog_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[4] && !(wr_valid && wr_ready && wr_code == 8'h50 && status_o[7]))
      |=> status_o[4]);

  assert_no_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[0] |-> !wr_ready);
endmodule

bind stream_prog_seq sp_checks #(.BUF_W(BUF_W)) u_sp_checks (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_code  (wr_data[7:0]),
  .status_o (status_o)
);

// File: tb/stream_prog_seq_bench.sv
module stream_prog_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [6:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        vpp_ok = 1'b1;
  logic [1:0]  blk_lock = 2'b00;
  logic [7:0]  status_o;
  logic [6:0]  rd_addr = '0;
  logic [15:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stream_prog_seq u_stream_prog_seq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .vpp_ok(vpp_ok), .blk_lock(blk_lock),
    .status_o(status_o), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  typedef struct packed {
    logic [6:0] addr;
    logic [7:0] code;
    logic       vpp;
    logic [1:0] lock;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{7'h00, 8'hD0, 1'b1, 2'b00, 8'h00},
    '{7'h00, 8'hFF, 1'b1, 2'b00, 8'h90},
    '{7'h05, 8'hD0, 1'b1, 2'b00, 8'h90},
    '{7'h40, 8'hD0, 1'b1, 2'b10, 8'h90},
    '{7'h00, 8'hD0, 1'b0, 2'b00, 8'h98},
    '{7'h20, 8'hD0, 1'b1, 2'b00, 8'h00},
    '{7'h60, 8'hD0, 1'b1, 2'b01, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_commit(output int n);
    n = 0;
    while (status_o[0]) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic peek(input logic [6:0] a, output logic [15:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 status", status_o, 8'h80);
    chk("R1 ready", wr_ready, 1'b1);
    peek(7'h00, d); chk("R1 array[00]", d, 16'hFFFF);
    peek(7'h7F, d); chk("R1 array[7F]", d, 16'hFFFF);

    // Table walk of entry checks (R2, R3, R4)
    for (int i = 0; i < 7; i++) begin
      wr(7'h00, 16'h0050);
      wr(VECS[i].addr, 16'h0080);
      vpp_ok   = VECS[i].vpp;
      blk_lock = VECS[i].lock;
      wr(VECS[i].addr, {8'h00, VECS[i].code});
      if (VECS[i].exp == 8'h00)   chk("R2 entry accepted", status_o, VECS[i].exp);
      else if (VECS[i].exp[3])    chk("R4 low voltage", status_o, VECS[i].exp);
      else                        chk("R3 entry rejected", status_o, VECS[i].exp);
      vpp_ok   = 1'b1;
      blk_lock = 2'b00;
      if (VECS[i].exp[7] == 1'b0) begin
        wr(VECS[i].addr ^ 7'h01, 16'h00FF);
        chk("R7 empty exit", status_o, 8'h80);
      end
    end

    // Two full buffers into block 1, then past its end
    wr(7'h00, 16'h0050);
    wr(7'h40, 16'h0080);
    wr(7'h40, 16'h00D0);
    chk("R2 block1 entry", status_o, 8'h00);
    for (int i = 0; i < 32; i++) wr(7'h40, 16'h1000 + 16'(i));
    chk("R11 ready low in commit", wr_ready, 1'b0);
    wait_commit(n);
    chk("R5 commit cycles", n, 32);
    chk("R5 status after commit", status_o, 8'h00);
    for (int i = 0; i < 32; i++) wr(7'h40, 16'h2000 + 16'(i));
    wait_commit(n);
    chk("R5 second commit cycles", n, 32);
    peek(7'h40, d); chk("R5 word0", d, 16'h1000);
    peek(7'h5F, d); chk("R5 word31", d, 16'h101F);
    peek(7'h60, d); chk("R6 next buffer word0", d, 16'h2000);
    peek(7'h7F, d); chk("R6 next buffer word31", d, 16'h201F);
    wr(7'h40, 16'h3333);
    chk("R8 past block end", status_o, 8'hB0);
    peek(7'h00, d); chk("R8 no wrap write", d, 16'hFFFF);
    wr(7'h00, 16'h1234);
    chk("R10 other code ignored", status_o, 8'hB0);
    wr(7'h00, 16'h0050);
    chk("R10 clear", status_o, 8'h80);

    // Partial buffer closed by an exit write
    wr(7'h00, 16'h0080);
    wr(7'h00, 16'h00D0);
    for (int i = 0; i < 5; i++) wr(7'h00, 16'h00A0 + 16'(i));
    wr(7'h10, 16'h0000);
    chk("R7 partial commit busy", status_o[0], 1'b1);
    wait_commit(n);
    chk("R7 status after exit", status_o, 8'h80);
    peek(7'h00, d); chk("R7 word0", d, 16'h00A0);
    peek(7'h04, d); chk("R7 word4", d, 16'h00A4);
    peek(7'h05, d); chk("R7 unfilled word5", d, 16'hFFFF);
    peek(7'h1F, d); chk("R7 unfilled word31", d, 16'hFFFF);

    // Rewriting programmed cells with ones fails verification
    wr(7'h00, 16'h0080);
    wr(7'h00, 16'h00D0);
    for (int i = 0; i < 32; i++) wr(7'h00, 16'hFFFF);
    wait_commit(n);
    chk("R9 abort after first word", n, 1);
    chk("R9 verify error status", status_o, 8'h90);
    peek(7'h00, d); chk("R9 cell unchanged", d, 16'h00A0);
    wr(7'h00, 16'h00D0);
    chk("R10 sticky after stray confirm", status_o, 8'h90);
    wr(7'h00, 16'h0050);
    chk("R10 cleared", status_o, 8'h80);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule